// File: doc/BRIEF.md
# Shared-Counter Multichannel Ramp Digitizer Back End

This block is the digital half of a many-channel ramp-compare converter. A single conversion counter runs once per conversion and its value is broadcast to every channel in Gray code, so that a channel sampling the bus at any moment sees at most one bit in transition. Each channel watches its own end-of-ramp comparator bit. The first rising edge of that bit within a conversion freezes the broadcast count into the channel's result register. The analog ramp and the comparators are outside the block. The `ramp_go` output tells the ramp generator when to run.

A conversion starts with a one-cycle `conv_start` strobe. It ends as soon as every channel has captured, or when the counter reaches its terminal value. At the terminal value, any channel that never fired is loaded with the saturated code. Comparator bits pass through a synchronizer before edge detection. A parameter chooses whether the results come out as plain binary or as the raw Gray code.

Top module: `wilk_digitizer`

## Requirements
- R1: While `rst` is high and in the cycle after it, `ramp_go` and `all_done` are 0 and every result field is 0.
- R2: The clock edge that samples `conv_start` high clears every result to 0, clears `all_done` and sets `ramp_go`. The counter restarts at 0 on that edge and increments by one on each later edge while `ramp_go` is high.
- R3: Consider a comparator bit that is first sampled high on the k-th rising edge after the edge that registered `conv_start`. Its channel's result becomes the count k+1 (binary value), because of two synchronizer stages and one capture register.
- R4: A channel captures only once per conversion. Its comparator falling and rising again before the conversion ends does not change its result.
- R5: A channel whose comparator has not risen by the time the counter reaches 2^RES_W-1 is loaded with the saturated binary value 2^RES_W-1 (4095 for 12 bits).
- R6: When every channel has captured, `all_done` goes to 1 and `ramp_go` to 0 one edge after the last capture. With the latest comparator first sampled on edge k, this is k+3 edges after the start edge.
- R7: If some channel never fires, `all_done` goes to 1 and `ramp_go` to 0 exactly 2^RES_W edges after the start edge.
- R8: With DECODE=1 each field of `results` is binary. With DECODE=0 each field is the Gray code g = b XOR (b>>1) of that same binary value, including the saturated code.
- R9: While `ramp_go` is 0 and no start is sampled, comparator activity has no effect: `results` holds its value and `all_done` keeps its level.

Channel i occupies `results[i*RES_W +: RES_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | One-cycle strobe that begins a conversion |
| cmp_done | input | NCH | Per-channel end-of-ramp comparator bits, asynchronous |
| ramp_go | output | 1 | High while the ramp and counter run |
| all_done | output | 1 | High after the conversion has finished |
| results | output | NCH*RES_W | Packed per-channel results |

## Verification
The bench places comparator edges at known cycle offsets and expects an exact count of k+1. A design that dropped a synchronizer stage or sampled the counter one register late would be off by one on every channel. It toggles already-captured comparators mid-conversion, which catches a design that re-latches on later edges. It leaves one channel silent so that it must saturate to 4095, and it checks that the conversion ends at exactly 4096 cycles. An early or late terminal test, or a missing saturation load, would show up as a wrong latency or a stale zero. It also fires a channel close to the terminal count. A second instance with Gray output confirms the encoding of every field, and comparator activity after completion must leave the results untouched.

// File: rtl/wdig_pkg.sv
package wdig_pkg;
   localparam int MAXW = 16;

   typedef logic [MAXW-1:0] word_t;

   function automatic word_t bin_to_gray(input word_t b);
      return b ^ (b >> 1);
   endfunction

   function automatic word_t gray_to_bin(input word_t g);
      word_t b;
      for (int i = 0; i < MAXW; i++) begin
         b[i] = ^(g >> i);
      end
      return b;
   endfunction
endpackage

// File: rtl/wdig_sync.sv
module wdig_sync #(
   parameter int N      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] din,
   output logic [N-1:0] dout
);
   logic [N-1:0] stg_q [STAGES];

   always_ff @(posedge clk) begin
      if (rst) stg_q[0] <= '0;
      else     stg_q[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) stg_q[s] <= '0;
         else     stg_q[s] <= stg_q[s-1];
      end
   end

   assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/wdig_count.sv
module wdig_count
   import wdig_pkg::*;
#(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         stop,
   output logic         running,
   output logic         wrap,
   output logic [W-1:0] gray_q
);
   logic [W-1:0] bin_q;
   logic [W-1:0] bin_nxt;
   logic         at_top;

   assign at_top  = (bin_q == {W{1'b1}});
   assign bin_nxt = bin_q + 1'b1;
   assign wrap    = running & at_top;

   always_ff @(posedge clk) begin
      if (rst) begin
         bin_q   <= '0;
         gray_q  <= '0;
         running <= 1'b0;
      end else if (start) begin
         bin_q   <= '0;
         gray_q  <= '0;
         running <= 1'b1;
      end else if (running) begin
         if (at_top || stop) begin
            running <= 1'b0;
         end else begin
            bin_q  <= bin_nxt;
            gray_q <= W'(bin_to_gray(MAXW'(bin_nxt)));
         end
      end
   end
endmodule

// File: rtl/wdig_lane.sv
module wdig_lane
   import wdig_pkg::*;
#(
   parameter int W      = 12,
   parameter bit DECODE = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start,
   input  logic         running,
   input  logic         wrap,
   input  logic         cmp_s,
   input  logic [W-1:0] gray_bus,
   output logic         hit,
   output logic [W-1:0] result
);
   logic         prev_q;
   logic         rise;
   logic [W-1:0] cap_val;
   logic [W-1:0] sat_val;

   assign rise = cmp_s & ~prev_q;

   if (DECODE) begin : g_binary
      assign cap_val = W'(gray_to_bin(MAXW'(gray_bus)));
      assign sat_val = {W{1'b1}};
   end else begin : g_gray
      assign cap_val = gray_bus;
      assign sat_val = {1'b1, {(W-1){1'b0}}};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= 1'b0;
         hit    <= 1'b0;
         result <= '0;
      end else begin
         prev_q <= cmp_s;
         if (start) begin
            hit    <= 1'b0;
            result <= '0;
         end else if (running && !hit) begin
            if (rise) begin
               hit    <= 1'b1;
               result <= cap_val;
            end else if (wrap) begin
               hit    <= 1'b1;
               result <= sat_val;
            end
         end
      end
   end
endmodule

// File: rtl/wilk_digitizer.sv
module wilk_digitizer
   import wdig_pkg::*;
#(
   parameter int NCH         = 36,
   parameter int RES_W       = 12,
   parameter int SYNC_STAGES = 2,
   parameter bit DECODE      = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 conv_start,
   input  logic [NCH-1:0]       cmp_done,
   output logic                 ramp_go,
   output logic                 all_done,
   output logic [NCH*RES_W-1:0] results
);
   localparam int BUS_W = NCH * RES_W;

   if (RES_W < 2 || RES_W > MAXW) begin : g_bad_width
      $error("RES_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be positive");
   end

   logic [NCH-1:0]   cmp_s;
   logic [NCH-1:0]   hit_v;
   logic [RES_W-1:0] gray_bus;
   logic             running;
   logic             wrap;
   logic             all_hit;
   logic             done_q;
   logic [BUS_W-1:0] res_bus;

   wdig_sync #(.N(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (cmp_done),
      .dout(cmp_s)
   );

   assign all_hit = &hit_v;

   wdig_count #(.W(RES_W)) u_count (
      .clk    (clk),
      .rst    (rst),
      .start  (conv_start),
      .stop   (all_hit),
      .running(running),
      .wrap   (wrap),
      .gray_q (gray_bus)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_lane
      wdig_lane #(.W(RES_W), .DECODE(DECODE)) u_lane (
         .clk     (clk),
         .rst     (rst),
         .start   (conv_start),
         .running (running),
         .wrap    (wrap),
         .cmp_s   (cmp_s[i]),
         .gray_bus(gray_bus),
         .hit     (hit_v[i]),
         .result  (res_bus[i*RES_W +: RES_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst)                           done_q <= 1'b0;
      else if (conv_start)               done_q <= 1'b0;
      else if (running && (all_hit || wrap)) done_q <= 1'b1;
   end

   assign ramp_go  = running;
   assign all_done = done_q;
   assign results  = res_bus;
endmodule

// File: rtl/wilk_digitizer_chk.sv
module wilk_digitizer_chk #(
   parameter int NCH   = 36,
   parameter int RES_W = 12
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 conv_start,
   input logic                 ramp_go,
   input logic                 all_done,
   input logic [NCH*RES_W-1:0] results
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (!ramp_go && !all_done && results == '0));

   // R2
   start_runs_chk: assert property (@(posedge clk) disable iff (rst)
      conv_start |=> (ramp_go && !all_done && results == '0));

   // R6
   done_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(all_done && ramp_go));

   // R7
   done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(all_done) |-> $past(ramp_go));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!ramp_go && !conv_start) |=> ($stable(results) && $stable(all_done)));
endmodule

bind wilk_digitizer wilk_digitizer_chk #(.NCH(NCH), .RES_W(RES_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .conv_start(conv_start),
   .ramp_go   (ramp_go),
   .all_done  (all_done),
   .results   (results)
);

// File: tb/wilk_digitizer_test.sv
`timescale 1ns/1ps
module wilk_digitizer_test;
   localparam int NCH   = 4;
   localparam int RES_W = 12;
   localparam int TOP   = (1 << RES_W) - 1;
   localparam real TCK  = 20.0;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 conv_start = 1'b0;
   logic [NCH-1:0]       cmp_done = '0;
   logic                 ramp_go, all_done, ramp_go_g, all_done_g;
   logic [NCH*RES_W-1:0] results, results_g;

   int n_chk  = 0;
   int n_fail = 0;
   int exp_q[$];
   int lat_q[$];
   int last_exp [NCH];
   int run_len = 0;
   bit done_prev = 1'b0;

   always #(TCK/2) clk = ~clk;

   wilk_digitizer #(.NCH(NCH), .RES_W(RES_W), .DECODE(1'b1)) uut (
      .clk(clk), .rst(rst), .conv_start(conv_start), .cmp_done(cmp_done),
      .ramp_go(ramp_go), .all_done(all_done), .results(results));

   wilk_digitizer #(.NCH(NCH), .RES_W(RES_W), .DECODE(1'b0)) uut_gray (
      .clk(clk), .rst(rst), .conv_start(conv_start), .cmp_done(cmp_done),
      .ramp_go(ramp_go_g), .all_done(all_done_g), .results(results_g));

   function automatic int b2g(input int b);
      return b ^ (b >> 1);
   endfunction

   function automatic int field(input logic [NCH*RES_W-1:0] v, input int i);
      return int'(v[i*RES_W +: RES_W]);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst) begin
         run_len   = 0;
         done_prev = 1'b0;
      end else begin
         run_len++;
         if (conv_start) run_len = -1;
         if (all_done && !done_prev) begin
            if (lat_q.size() == 0 || exp_q.size() < NCH) begin
               check(1'b0, "R6 unexpected done", 1, 0);
            end else begin
               int lat;
               lat = lat_q.pop_front();
               check(run_len == lat, "R6/R7 done latency", run_len, lat);
               check(ramp_go == 1'b0, "R6 ramp_go low at done", ramp_go, 0);
               check(all_done_g == 1'b1, "R8 gray instance done", all_done_g, 1);
               for (int i = 0; i < NCH; i++) begin
                  int e;
                  e = exp_q.pop_front();
                  check(field(results, i) == e, "R3/R5 binary result", field(results, i), e);
                  check(field(results_g, i) == b2g(e), "R8 gray result",
                        field(results_g, i), b2g(e));
               end
            end
         end
         done_prev = all_done;
      end
   end

   // driver: d<0 means the comparator never fires
   task automatic run_conv(input int d [NCH], input bit tog);
      int maxd;
      bit silent;
      maxd = 0;
      silent = 1'b0;
      for (int i = 0; i < NCH; i++) begin
         int e;
         if (d[i] < 0) begin
            silent = 1'b1;
            e = TOP;
         end else begin
            e = (d[i] + 1 > TOP) ? TOP : d[i] + 1;
            if (d[i] > maxd) maxd = d[i];
         end
         last_exp[i] = e;
         exp_q.push_back(e);
      end
      lat_q.push_back((silent || maxd + 3 > TOP + 1) ? TOP + 1 : maxd + 3);
      cmp_done = '0;
      repeat (4) @(negedge clk);
      conv_start = 1'b1;
      for (int t = 1; t < 6000; t++) begin
         @(negedge clk);
         if (t == 1) begin
            conv_start = 1'b0;
            // R2
            check(ramp_go == 1'b1, "R2 ramp_go after start", ramp_go, 1);
            check(all_done == 1'b0, "R2 done cleared", all_done, 0);
            check(results == '0, "R2 results cleared", int'(results[RES_W-1:0]), 0);
         end
         if (all_done) break;
         for (int i = 0; i < NCH; i++) begin
            bit v;
            v = (d[i] >= 0) && (t >= d[i]);
            // R4: re-toggle captured comparators before the conversion ends
            if (tog && i < NCH - 1 && d[i] >= 0 && t >= d[i] + 5 && t < d[i] + 10) v = 1'b0;
            cmp_done[i] = v;
         end
      end
      cmp_done = '0;
   endtask

   initial begin
      #(TCK * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int da [NCH];
      int db [NCH];
      int dc [NCH];
      repeat (3) @(negedge clk);
      // R1
      check(ramp_go == 1'b0, "R1 reset ramp_go", ramp_go, 0);
      check(all_done == 1'b0, "R1 reset all_done", all_done, 0);
      check(results == '0, "R1 reset results", int'(results[RES_W-1:0]), 0);
      rst = 1'b0;
      @(negedge clk);
      check(results == '0 && !ramp_go, "R1 after reset", int'(ramp_go), 0);

      // R3 R6: all channels fire
      da = '{5, 17, 300, 1000};
      run_conv(da, 1'b0);
      // R4: captured channels re-toggle before last one fires
      db = '{10, 20, 30, 400};
      run_conv(db, 1'b1);
      // R5 R7: one silent channel, one firing close to the terminal count
      dc = '{1, 4000, -1, 64};
      run_conv(dc, 1'b0);

      // R9: comparator activity while idle
      for (int t = 0; t < 20; t++) begin
         @(negedge clk);
         cmp_done = NCH'(t);
      end
      cmp_done = '0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
         check(field(results, i) == last_exp[i], "R9 idle hold", field(results, i), last_exp[i]);
      end
      check(all_done == 1'b1 && ramp_go == 1'b0, "R9 done level kept", all_done, 1);

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0 && lat_q.size() == 0, "R6 all conversions completed",
            exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule